// File: doc/BRIEF.md
# Feedback comb delay with tail drain

This block is a streaming echo stage for 16-bit signed audio samples. A circular sample buffer holds the recirculating signal. For every accepted input sample, one stored sample is read from the buffer. The output is the input plus that delayed sample. The stored sample is then scaled by an unsigned fractional feedback gain, added to the input, and written back into the same slot. The sum saturates instead of wrapping. The delay runs from 1 up to `MAX_DEPTH` samples and is set by a length input.

When the effect is switched off, new input stops entering the loop, but the echo tail keeps circulating and fading at the programmed gain. On entry to the drain, the block works out how many full buffer passes it takes for the gain to bring the tail about 120 dB down. After that many passes it writes zeros through the whole buffer, one entry per clock, and then rests idle. The output stays zero until the effect is switched back on.

The controller has four states: CLEAR (zero sweep), IDLE (waiting for enable), RUN (echo active) and DRAIN (tail only). It has five transitions. CLEAR→IDLE happens when the sweep reaches the last entry. IDLE→RUN happens on enable. RUN→DRAIN happens on disable. DRAIN→RUN happens on re-enable. DRAIN→CLEAR happens when the pass budget is spent. Reset enters CLEAR.

Top module: `echo_drain`

## Requirements
- R1: In RUN, the delay is `dly_len`+1 samples. Each accepted sample produces `out_data` = sat(`in_data` + the value written to the buffer `dly_len`+1 accepted samples earlier, or zero if the buffer was cleared since).
- R2: In RUN, the value written back is sat(`in_data` + floor(rd × `fb_gain` / 256)). Here rd is the delayed sample and `fb_gain` is unsigned with 8 fractional bits, so 128 means one half. The floor rounds toward minus infinity.
- R3: Every sum saturates to the range −32768 … 32767 and never wraps.
- R4: In DRAIN, `in_data` is ignored. `out_data` equals the delayed sample, and the value written back is floor(rd × g / 256).
- R5: On leaving RUN, the pass budget n is computed from the gain at that moment. Start with a = 2^20 and repeat a ← floor(a × g / 256), counting steps, until a ≤ 1. A gain of 26 gives 6, and a gain of 0 gives 1.
- R6: A pass is counted when the pointer wraps from `dly_len` back to 0 in DRAIN. The sample that makes the n-th wrap ends the drain. The block then zeroes all `MAX_DEPTH` entries, one per clock, and returns `out_data` = 0 for every sample until it is back in RUN.
- R7: Raising `fx_enable` during DRAIN returns the block to RUN at once. The remaining tail and the pointer position are kept.
- R8: A change of `dly_len` while the loop runs (RUN or DRAIN) sets the pointer to 0 on the next clock.
- R9: Reset drives `out_valid` and `out_data` to 0 and enters CLEAR, so the buffer reads as zeros once the block reaches RUN.
- R10: In every state, `out_valid` is `in_valid` delayed by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fx_enable | input | 1 | Effect on (1) or off (0) |
| dly_len | input | 10 | Delay length minus one, in samples |
| fb_gain | input | 8 | Feedback gain, unsigned, 8 fractional bits |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Output sample, signed |

## Verification
A wrong pointer or a stale buffer entry shows in the first sample that reads the bad slot: that is, within `dly_len`+1 accepted samples. A wrong pass budget or a wrong wrap count shows at the end of the drain. The bench feeds a negative tail, which under floor rounding settles at −1 and never reaches zero on its own. The output then turns to zero one pass too early or too late, which is visible one sample after the deciding wrap. An incomplete clear sweep shows in the first buffer length of samples after re-enable, where the output must equal the input exactly.

// File: rtl/echo_pkg.sv
`timescale 1ns/1ps
package echo_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } echo_state_e;

endpackage

// File: rtl/echo_mix.sv
`timescale 1ns/1ps
module echo_mix #(
    parameter int DATA_W = 16,
    parameter int GAIN_W = 8
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] rd,
    input  logic        [GAIN_W-1:0] g,
    output logic signed [DATA_W-1:0] mix,
    output logic signed [DATA_W-1:0] fb
);
    localparam int WIDE = DATA_W + GAIN_W + 1;
    localparam logic signed [WIDE-1:0] HI = $signed(WIDE'((1 << (DATA_W-1)) - 1));
    localparam logic signed [WIDE-1:0] LO = -HI - 1;

    function automatic logic signed [DATA_W-1:0] clip(input logic signed [WIDE-1:0] v);
        if (v > HI)      clip = HI[DATA_W-1:0];
        else if (v < LO) clip = LO[DATA_W-1:0];
        else             clip = v[DATA_W-1:0];
    endfunction

    logic signed [WIDE-1:0] prod;
    logic signed [WIDE-1:0] scaled;
    logic signed [WIDE-1:0] sum_fb;
    logic signed [WIDE-1:0] sum_mix;

    always_comb begin
        prod    = WIDE'(rd) * $signed({1'b0, g});
        scaled  = prod >>> GAIN_W;
        sum_fb  = WIDE'(x) + scaled;
        sum_mix = WIDE'(x) + WIDE'(rd);
        fb      = clip(sum_fb);
        mix     = clip(sum_mix);
    end
endmodule

// File: rtl/echo_ram.sv
`timescale 1ns/1ps
module echo_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/echo_budget.sv
`timescale 1ns/1ps
module echo_budget #(
    parameter int GAIN_W     = 8,
    parameter int ATTEN_BITS = 20,
    parameter int CNT_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GAIN_W-1:0] gain,
    output logic              ready,
    output logic [CNT_W-1:0]  passes
);
    localparam int PW = ATTEN_BITS + GAIN_W + 1;

    logic [PW-1:0]     acc_q;
    logic [PW-1:0]     prod;
    logic [GAIN_W-1:0] g_q;
    logic [CNT_W-1:0]  n_q;
    logic              busy_q;
    logic              ready_q;

    assign prod = acc_q * PW'(g_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            g_q     <= '0;
            n_q     <= '0;
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
        end else if (start) begin
            acc_q   <= PW'(1) << ATTEN_BITS;
            g_q     <= gain;
            n_q     <= '0;
            busy_q  <= 1'b1;
            ready_q <= 1'b0;
        end else if (busy_q) begin
            if (acc_q <= PW'(1) || (&n_q)) begin
                busy_q  <= 1'b0;
                ready_q <= 1'b1;
            end else begin
                acc_q <= prod >> GAIN_W;
                n_q   <= n_q + CNT_W'(1);
            end
        end
    end

    assign ready  = ready_q;
    assign passes = n_q;
endmodule

// File: rtl/echo_drain.sv
`timescale 1ns/1ps
module echo_drain #(
    parameter int DATA_W     = 16,
    parameter int GAIN_W     = 8,
    parameter int MAX_DEPTH  = 1024,
    parameter int ATTEN_BITS = 20,
    parameter int CNT_W      = 12,
    localparam int AW        = $clog2(MAX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fx_enable,
    input  logic [AW-1:0]     dly_len,
    input  logic [GAIN_W-1:0] fb_gain,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import echo_pkg::*;

    echo_state_e       state_q, state_d;
    logic [AW-1:0]     ptr_q;
    logic [AW-1:0]     cptr_q;
    logic [AW-1:0]     len_q;
    logic [CNT_W-1:0]  wraps_q;
    logic [DATA_W-1:0] rd;
    logic signed [DATA_W-1:0] mix, fb, x_eff;
    logic              looping, proc, wrap, len_moved, sweep_end;
    logic              b_start, b_ready, drain_done;
    logic [CNT_W-1:0]  b_passes;
    logic              we;
    logic [AW-1:0]     waddr;
    logic [DATA_W-1:0] wdata;

    assign looping   = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    assign proc      = looping && in_valid;
    assign wrap      = (ptr_q == len_q);
    assign len_moved = (dly_len != len_q);
    assign sweep_end = (cptr_q == AW'(MAX_DEPTH - 1));
    assign b_start   = (state_q == ST_RUN) && !fx_enable;
    assign x_eff     = (state_q == ST_RUN) ? $signed(in_data) : '0;

    assign drain_done = b_ready &&
                        ((wraps_q >= b_passes) ||
                         (proc && wrap && ((wraps_q + CNT_W'(1)) >= b_passes)));

    echo_ram #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(ptr_q), .rdata(rd)
    );

    echo_mix #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_mix (
        .x(x_eff), .rd($signed(rd)), .g(fb_gain), .mix(mix), .fb(fb)
    );

    echo_budget #(.GAIN_W(GAIN_W), .ATTEN_BITS(ATTEN_BITS), .CNT_W(CNT_W)) u_budget (
        .clk(clk), .rst_n(rst_n), .start(b_start), .gain(fb_gain),
        .ready(b_ready), .passes(b_passes)
    );

    assign we    = (state_q == ST_CLEAR) || proc;
    assign waddr = (state_q == ST_CLEAR) ? cptr_q : ptr_q;
    assign wdata = (state_q == ST_CLEAR) ? '0 : fb;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (sweep_end)       state_d = ST_IDLE;
            ST_IDLE:  if (fx_enable)       state_d = ST_RUN;
            ST_RUN:   if (!fx_enable)      state_d = ST_DRAIN;
            ST_DRAIN: if (fx_enable)       state_d = ST_RUN;
                      else if (drain_done) state_d = ST_CLEAR;
            default:                       state_d = ST_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // pointers and pass counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            cptr_q  <= '0;
            len_q   <= '0;
            wraps_q <= '0;
        end else begin
            len_q <= dly_len;
            unique case (state_q)
                ST_CLEAR: begin
                    ptr_q  <= '0;
                    cptr_q <= cptr_q + AW'(1);
                end
                ST_IDLE: begin
                    ptr_q  <= '0;
                    cptr_q <= '0;
                end
                ST_RUN, ST_DRAIN: begin
                    cptr_q <= '0;
                    if (state_q == ST_RUN) wraps_q <= '0;
                    if (len_moved) begin
                        ptr_q <= '0;
                    end else if (in_valid) begin
                        ptr_q <= wrap ? '0 : ptr_q + AW'(1);
                        if (wrap && state_q == ST_DRAIN) wraps_q <= wraps_q + CNT_W'(1);
                    end
                end
                default: ptr_q <= '0;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= proc ? mix : '0;
        end
    end
endmodule

// File: rtl/echo_drain_chk.sv
`timescale 1ns/1ps
module echo_drain_chk #(
    parameter int DATA_W    = 16,
    parameter int MAX_DEPTH = 1024,
    localparam int AW       = $clog2(MAX_DEPTH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fx_enable,
    input logic [AW-1:0]        dly_len,
    input logic                 in_valid,
    input logic [DATA_W-1:0]    in_data,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    out_data,
    input echo_pkg::echo_state_e state,
    input logic [AW-1:0]        ptr,
    input logic [AW-1:0]        len_q,
    input logic [AW-1:0]        cptr,
    input logic [DATA_W-1:0]    rd
);
    import echo_pkg::*;

    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_silent_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (state == ST_CLEAR || state == ST_IDLE)) |=> (out_data == '0));

    p_sweep_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && cptr != AW'(MAX_DEPTH - 1)) |=> (state == ST_CLEAR));

    p_ptr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN || state == ST_DRAIN) |-> (ptr <= len_q));

    p_len_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN || state == ST_DRAIN) && dly_len != len_q) |=> (ptr == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && in_valid && !in_data[DATA_W-1] && !rd[DATA_W-1])
        |=> !out_data[DATA_W-1]);

    p_reenable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && fx_enable) |=> (state == ST_RUN));

    p_start_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fx_enable) |=> (state == ST_RUN && ptr == '0));
endmodule

bind echo_drain echo_drain_chk #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fx_enable(fx_enable), .dly_len(dly_len),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .state(state_q), .ptr(ptr_q), .len_q(len_q), .cptr(cptr_q), .rd(rd)
);

// File: tb/echo_drain_tb.sv
`timescale 1ns/1ps
module echo_drain_tb;
    localparam int DW = 16;
    localparam int GW = 8;
    localparam int DEPTH = 1024;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fx_enable = 1'b0;
    logic [AW-1:0] dly_len = '0;
    logic [GW-1:0] fb_gain = '0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model: 0 off, 1 run, 2 drain
    int m [DEPTH];
    int mp = 0, mL = 0, mg = 0, mw = 0, mn = 0, mst = 0;

    always #2.5 clk = ~clk;

    echo_drain u_dut (
        .clk(clk), .rst_n(rst_n), .fx_enable(fx_enable), .dly_len(dly_len),
        .fb_gain(fb_gain), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int clip16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int budget(input int g);
        int a = 1 << 20;
        int n = 0;
        while (a > 1) begin
            a = (a * g) >>> 8;
            n++;
        end
        return n;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) m[i] = 0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input int x, output int exp);
        int rd;
        rd = m[mp];
        if (mst == 1) begin
            exp = clip16(x + rd);
            m[mp] = clip16(x + ((rd * mg) >>> 8));
            mp = (mp == mL) ? 0 : mp + 1;
        end else if (mst == 2) begin
            exp = rd;
            m[mp] = (rd * mg) >>> 8;
            if (mp == mL) begin
                mp = 0;
                mw++;
                if (mw >= mn) begin
                    mst = 0;
                    model_clear();
                end
            end else begin
                mp++;
            end
        end else begin
            exp = 0;
        end
    endtask

    task automatic send(input int x, input string tag);
        int exp;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x[DW-1:0];
        model_step(x, exp);
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, out_valid ? int'($signed(out_data)) : -99999, exp);
    endtask

    task automatic set_gain(input int g);
        @(negedge clk);
        fb_gain = g[GW-1:0];
        mg = g;
    endtask

    task automatic set_len(input int l);
        @(negedge clk);
        dly_len = l[AW-1:0];
        @(negedge clk);
        mL = l;
        if (mst != 0) mp = 0;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        fx_enable = v;
        if (v && mst == 0) begin
            mst = 1;
            mp = 0;
        end else if (v && mst == 2) begin
            mst = 1;
        end else if (!v && mst == 1) begin
            mst = 2;
            mw = 0;
            mn = budget(mg);
        end
        @(negedge clk);
    endtask

    task automatic wait_sweep();
        repeat (1100) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R9 reset out_valid", int'(out_valid), 0);
        chk("R9 reset out_data", int'($signed(out_data)), 0);
        rst_n = 1'b1;
        model_clear();
        wait_sweep();
    endtask

    task automatic t_delay();
        set_gain(0);
        set_len(3);
        set_en(1'b1);
        send(1000, "R1 impulse");
        for (int i = 0; i < 8; i++) send((i == 2) ? -321 : 0, "R1 delay");
        repeat (3) @(negedge clk);
        chk("R10 no strobe", int'(out_valid), 0);
    endtask

    task automatic t_feedback();
        set_gain(128);
        send(-2000, "R2 impulse");
        for (int i = 0; i < 14; i++) send(0, "R2 decay");
        send(700, "R2 mixed");
        for (int i = 0; i < 6; i++) send(i * 11, "R2 mixed");
    endtask

    task automatic t_saturate();
        set_gain(255);
        set_len(1);
        for (int i = 0; i < 6; i++) send(30000, "R3 high");
        for (int i = 0; i < 8; i++) send(-30000, "R3 low");
    endtask

    task automatic t_length();
        set_gain(64);
        for (int i = 0; i < 4; i++) send(100 * i, "R8 before");
        set_len(5);
        send(4000, "R8 after");
        for (int i = 0; i < 8; i++) send(0, "R8 after");
    endtask

    task automatic t_drain();
        int guard;
        set_gain(26);
        set_len(9);
        for (int i = 0; i < 10; i++) send(-20000 + i * 1500, "R4 fill");
        set_en(1'b0);
        guard = 0;
        while (mst == 2 && guard < 200) begin
            send(1234, "R4/R5 drain");
            guard++;
        end
        chk("R5 drain sample count", guard, 60);
        for (int i = 0; i < 3; i++) send(555, "R6 silent");
        wait_sweep();
        set_en(1'b1);
        for (int i = 0; i < 10; i++) send(50 + i, "R6 cleared");
    endtask

    task automatic t_reenable();
        set_gain(128);
        set_len(7);
        for (int i = 0; i < 8; i++) send(-8000 + i * 2000, "R7 fill");
        set_en(1'b0);
        for (int i = 0; i < 3; i++) send(9999, "R7 drain");
        set_en(1'b1);
        for (int i = 0; i < 12; i++) send(i, "R7 resumed");
    endtask

    task automatic t_zero_gain();
        int guard;
        set_gain(0);
        set_len(4);
        for (int i = 0; i < 5; i++) send(-300 - i, "R5 fill");
        set_en(1'b0);
        guard = 0;
        while (mst == 2 && guard < 50) begin
            send(77, "R5 single pass");
            guard++;
        end
        chk("R5 zero gain pass length", guard, 5);
        send(9, "R6 after drain");
        wait_sweep();
    endtask

    initial begin
        t_reset();
        t_delay();
        t_feedback();
        t_saturate();
        t_length();
        t_drain();
        t_reenable();
        t_zero_gain();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule